// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block manages which oscillator or PLL drives the system clock. Software writes a small register set through a write port. It can turn the three oscillators (internal high-speed, internal low-power, external high-speed) on and off. It can also turn PLLs on and off, choose the PLL reference, set the internal high-speed divider, and request a new system clock source. The analog oscillators and PLLs stay outside the block. Each one reports back through a ready input. The block drives the select lines of an external glitch-free clock mux.

A source request is held pending until the chosen source is both enabled and ready. The switch then happens, and the active-source output serves as both the mux select and the status software polls. The block guards the clock tree against software mistakes. It keeps an oscillator running while that oscillator feeds the system clock, directly or through PLL1. It keeps PLL1 running while PLL1 is the system clock. It freezes the PLL reference and the divider while changing them would disturb a running PLL. A low-power entry request shuts down the external oscillator and the PLLs and falls back to the internal high-speed oscillator.

Top module: `sysclk_src_ctrl`

## Requirements
- R1: After reset, sw_act and sw_req are 0 (internal high-speed), hsi_on is 1, csi_on, hse_on, hse_byp and all pll_on bits are 0, pll_ref is 0 and hsi_div is 0.
- R2: Source codes on sw_req, sw_act and pll_ref are 0 internal high-speed, 1 internal low-power, 2 external high-speed, 3 PLL1 output (pll_ref 3 selects no reference). Write register map by wr_addr:
  - 0: oscillator enables, with data bit 0 internal high-speed, bit 1 internal low-power, bit 2 external, bit 3 external bypass.
  - 1: PLL enables, with bit i for PLL i+1.
  - 2: pll_ref in bits [1:0].
  - 3: requested source in bits [1:0] and hsi_div in bits [DIV_W+1:2].
- R3: When sw_req differs from sw_act, and the requested source's enable and ready input are both high at a clock edge, sw_act takes the value of sw_req at that edge, one cycle after the request was written at the earliest.
- R4: A write to address 3 updates sw_req at the next edge. Until the requested source is ready, sw_act keeps the old source.
- R5: A write that would clear an oscillator enable leaves that enable at 1 in two cases: the oscillator is sw_act, or it is pll_ref while PLL1 is enabled and sw_act is 3. Enables of oscillators not in use follow the written bit.
- R6: A write that would clear the PLL1 enable leaves it at 1 while sw_act is 3. The other PLL enables follow the written bits.
- R7: The hsi_div field of a write to address 3 is dropped while pll_ref is 0 and any PLL is enabled. Otherwise it is taken, including while the internal high-speed oscillator drives the system clock directly.
- R8: A write to address 2 is dropped while any PLL enable is set.
- R9: The bypass bit is written only while hse_on is 0. hse_byp at 1 means that hse_on drives an external clock input instead of a crystal.
- R10: A cycle with lowpwr_req high sets, at the next edge, hse_on to 0, all pll_on to 0, hsi_on to 1 and both sw_req and sw_act to 0. Any register write in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lowpwr_req | input | 1 | Stop or standby entry request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DATA_W | Write data (DATA_W derived, 4 by default) |
| hsi_rdy | input | 1 | Internal high-speed oscillator stable |
| csi_rdy | input | 1 | Internal low-power oscillator stable |
| hse_rdy | input | 1 | External oscillator stable |
| pll_rdy | input | NUM_PLL | PLL lock flags, bit 0 is PLL1 |
| hsi_on | output | 1 | Internal high-speed oscillator enable |
| csi_on | output | 1 | Internal low-power oscillator enable |
| hse_on | output | 1 | External oscillator enable |
| hse_byp | output | 1 | External input is a clock, not a crystal |
| pll_on | output | NUM_PLL | PLL enables |
| pll_ref | output | 2 | PLL reference source code |
| hsi_div | output | DIV_W | Internal high-speed divider setting |
| sw_req | output | 2 | Requested system clock source |
| sw_act | output | 2 | Active source: mux select and status |

## Verification
The assertions check these rules on every cycle:
- sw_act moves only to the registered request, and only after that source was enabled and ready.
- A pending request leaves sw_act unchanged.
- An oscillator or PLL1 in use never loses its enable.
- pll_ref and hsi_div are frozen under their lock conditions.
- The bypass bit is frozen while the external oscillator runs.
- A low-power request forces the fallback state.

Only the bench scenarios show the remaining behaviour. This covers the accepted writes: clearing oscillators that are not in use, setting other PLL enables, divider writes while the internal oscillator runs the system clock directly, and bypass writes while the external oscillator is off. It also covers the exact register map and the discard of a write that coincides with low-power entry. The bench checks these through a reference model compared every cycle.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  typedef enum logic [1:0] {
    SRC_HSI = 2'd0,
    SRC_CSI = 2'd1,
    SRC_HSE = 2'd2,
    SRC_PLL = 2'd3
  } src_e;

  // oscillator vector indices, equal to their source codes
  localparam int unsigned N_OSC   = 3;
  localparam int unsigned IDX_HSI = 0;
  localparam int unsigned IDX_CSI = 1;
  localparam int unsigned IDX_HSE = 2;
  localparam int unsigned BIT_BYP = 3;
  localparam int unsigned DIV_LSB = 2;

  localparam logic [1:0] REG_OSC = 2'd0;
  localparam logic [1:0] REG_PLL = 2'd1;
  localparam logic [1:0] REG_REF = 2'd2;
  localparam logic [1:0] REG_CFG = 2'd3;

  function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sysclk_usage.sv
// Flags each oscillator that currently feeds the system clock, directly
// or as the reference of PLL1 while PLL1 is the active source.
module sysclk_usage
  import sysclk_pkg::*;
(
  input  logic [1:0]       act,
  input  logic [1:0]       ref_sel,
  input  logic             pll1_on,
  output logic [N_OSC-1:0] osc_busy,
  output logic             pll1_busy
);

  logic via_pll;

  assign pll1_busy = (act == SRC_PLL);
  assign via_pll   = pll1_busy && pll1_on;

  for (genvar g = 0; g < N_OSC; g++) begin : g_busy
    assign osc_busy[g] = (act == 2'(g)) || (via_pll && (ref_sel == 2'(g)));
  end

endmodule

// File: rtl/sysclk_switch.sv
// Holds the requested and active source; the active one follows the
// request only once the target is enabled and ready.
module sysclk_switch
  import sysclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             lowpwr_req,
  input  logic             req_wr,
  input  logic [1:0]       req_data,
  input  logic [N_OSC-1:0] osc_on,
  input  logic [N_OSC-1:0] osc_rdy,
  input  logic             pll1_on,
  input  logic             pll1_rdy,
  output logic [1:0]       sw_req,
  output logic [1:0]       sw_act
);

  logic [3:0] src_ok_vec;
  logic       src_ok;

  assign src_ok_vec = {pll1_on & pll1_rdy, osc_on & osc_rdy};
  assign src_ok     = src_ok_vec[sw_req];

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_req <= SRC_HSI;
      sw_act <= SRC_HSI;
    end else if (lowpwr_req) begin
      sw_req <= SRC_HSI;
      sw_act <= SRC_HSI;
    end else begin
      if (req_wr) sw_req <= req_data;
      if ((sw_req != sw_act) && src_ok) sw_act <= sw_req;
    end
  end

endmodule

// File: rtl/sysclk_osc_regs.sv
// Oscillator, PLL, reference and divider registers with write guards.
module sysclk_osc_regs
  import sysclk_pkg::*;
#(
  parameter int unsigned NUM_PLL = 3,
  parameter int unsigned DIV_W   = 2,
  parameter int unsigned DATA_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lowpwr_req,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [N_OSC-1:0]   osc_busy,
  input  logic               pll1_busy,
  output logic [N_OSC-1:0]   osc_on,
  output logic               hse_byp,
  output logic [NUM_PLL-1:0] pll_on,
  output logic [1:0]         pll_ref,
  output logic [DIV_W-1:0]   hsi_div
);

  logic wr_osc, wr_pll, wr_ref, wr_cfg;
  logic ref_lock, div_lock;
  logic [N_OSC-1:0]   osc_next;
  logic [NUM_PLL-1:0] pll_keep;
  logic [NUM_PLL-1:0] pll_next;

  assign wr_osc = wr_en && (wr_addr == REG_OSC);
  assign wr_pll = wr_en && (wr_addr == REG_PLL);
  assign wr_ref = wr_en && (wr_addr == REG_REF);
  assign wr_cfg = wr_en && (wr_addr == REG_CFG);

  assign ref_lock = |pll_on;
  assign div_lock = (pll_ref == SRC_HSI) && (|pll_on);

  // an enable in use survives a write of zero
  assign osc_next = wr_data[N_OSC-1:0] | (osc_on & osc_busy);

  always_comb begin
    pll_keep    = '0;
    pll_keep[0] = pll1_busy & pll_on[0];
  end
  assign pll_next = wr_data[NUM_PLL-1:0] | pll_keep;

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_on          <= '0;
      osc_on[IDX_HSI] <= 1'b1;
      hse_byp         <= 1'b0;
      pll_on          <= '0;
      pll_ref         <= SRC_HSI;
      hsi_div         <= '0;
    end else if (lowpwr_req) begin
      osc_on[IDX_HSI] <= 1'b1;
      osc_on[IDX_HSE] <= 1'b0;
      pll_on          <= '0;
    end else begin
      if (wr_osc) begin
        osc_on <= osc_next;
        if (!osc_on[IDX_HSE]) hse_byp <= wr_data[BIT_BYP];
      end
      if (wr_pll) pll_on <= pll_next;
      if (wr_ref && !ref_lock) pll_ref <= wr_data[1:0];
      if (wr_cfg && !div_lock) hsi_div <= wr_data[DIV_LSB +: DIV_W];
    end
  end

endmodule

// File: rtl/sysclk_src_ctrl.sv
module sysclk_src_ctrl
  import sysclk_pkg::*;
#(
  parameter int unsigned NUM_PLL = 3,
  parameter int unsigned DIV_W   = 2,
  localparam int unsigned DATA_W = wmax(wmax(BIT_BYP + 1, NUM_PLL), DIV_LSB + DIV_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lowpwr_req,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               hsi_rdy,
  input  logic               csi_rdy,
  input  logic               hse_rdy,
  input  logic [NUM_PLL-1:0] pll_rdy,
  output logic               hsi_on,
  output logic               csi_on,
  output logic               hse_on,
  output logic               hse_byp,
  output logic [NUM_PLL-1:0] pll_on,
  output logic [1:0]         pll_ref,
  output logic [DIV_W-1:0]   hsi_div,
  output logic [1:0]         sw_req,
  output logic [1:0]         sw_act
);

  logic [N_OSC-1:0] osc_on;
  logic [N_OSC-1:0] osc_rdy;
  logic [N_OSC-1:0] osc_busy;
  logic             pll1_busy;
  logic             req_wr;

  assign osc_rdy = {hse_rdy, csi_rdy, hsi_rdy};
  assign req_wr  = wr_en && (wr_addr == REG_CFG);

  assign hsi_on = osc_on[IDX_HSI];
  assign csi_on = osc_on[IDX_CSI];
  assign hse_on = osc_on[IDX_HSE];

  sysclk_usage u_usage (
    .act       (sw_act),
    .ref_sel   (pll_ref),
    .pll1_on   (pll_on[0]),
    .osc_busy  (osc_busy),
    .pll1_busy (pll1_busy)
  );

  sysclk_osc_regs #(
    .NUM_PLL (NUM_PLL),
    .DIV_W   (DIV_W),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .lowpwr_req (lowpwr_req),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .osc_busy   (osc_busy),
    .pll1_busy  (pll1_busy),
    .osc_on     (osc_on),
    .hse_byp    (hse_byp),
    .pll_on     (pll_on),
    .pll_ref    (pll_ref),
    .hsi_div    (hsi_div)
  );

  sysclk_switch u_switch (
    .clk        (clk),
    .rst        (rst),
    .lowpwr_req (lowpwr_req),
    .req_wr     (req_wr),
    .req_data   (wr_data[1:0]),
    .osc_on     (osc_on),
    .osc_rdy    (osc_rdy),
    .pll1_on    (pll_on[0]),
    .pll1_rdy   (pll_rdy[0]),
    .sw_req     (sw_req),
    .sw_act     (sw_act)
  );

endmodule

// File: rtl/sysclk_src_ctrl_chk.sv
module sysclk_src_ctrl_chk #(
  parameter int unsigned NUM_PLL = 3,
  parameter int unsigned DIV_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               lowpwr_req,
  input logic               hsi_rdy,
  input logic               csi_rdy,
  input logic               hse_rdy,
  input logic               pll1_rdy,
  input logic               hsi_on,
  input logic               csi_on,
  input logic               hse_on,
  input logic               hse_byp,
  input logic [NUM_PLL-1:0] pll_on,
  input logic [1:0]         pll_ref,
  input logic [DIV_W-1:0]   hsi_div,
  input logic [1:0]         sw_req,
  input logic [1:0]         sw_act
);

  logic req_ok;
  always_comb begin
    case (sw_req)
      2'd0:    req_ok = hsi_on & hsi_rdy;
      2'd1:    req_ok = csi_on & csi_rdy;
      2'd2:    req_ok = hse_on & hse_rdy;
      default: req_ok = pll_on[0] & pll1_rdy;
    endcase
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sw_act == 2'd0) && (sw_req == 2'd0) && hsi_on && !csi_on
                   && !hse_on && !hse_byp && (pll_on == '0) && (pll_ref == 2'd0)
                   && (hsi_div == '0));

  a_r3_switch_when_ready: assert property (@(posedge clk) disable iff (rst)
    ((sw_act != $past(sw_act)) && !$past(rst) && !$past(lowpwr_req))
      |-> (sw_act == $past(sw_req)) && $past(req_ok));

  a_r4_pending_holds: assert property (@(posedge clk) disable iff (rst)
    ((sw_req != sw_act) && !req_ok && !lowpwr_req) |=> $stable(sw_act));

  a_r5_hse_kept: assert property (@(posedge clk) disable iff (rst)
    ((sw_act == 2'd2) && hse_on && !lowpwr_req) |=> hse_on);

  a_r5_hsi_kept: assert property (@(posedge clk) disable iff (rst)
    ((sw_act == 2'd0) && hsi_on) |=> hsi_on);

  a_r5_ref_kept: assert property (@(posedge clk) disable iff (rst)
    ((sw_act == 2'd3) && pll_on[0] && (pll_ref == 2'd2) && hse_on && !lowpwr_req)
      |=> hse_on);

  a_r6_pll1_kept: assert property (@(posedge clk) disable iff (rst)
    ((sw_act == 2'd3) && pll_on[0] && !lowpwr_req) |=> pll_on[0]);

  a_r7_div_frozen: assert property (@(posedge clk) disable iff (rst)
    ((pll_ref == 2'd0) && (|pll_on)) |=> $stable(hsi_div));

  a_r8_ref_frozen: assert property (@(posedge clk) disable iff (rst)
    (|pll_on) |=> $stable(pll_ref));

  a_r9_byp_frozen: assert property (@(posedge clk) disable iff (rst)
    hse_on |=> $stable(hse_byp));

  a_r10_lowpwr_fallback: assert property (@(posedge clk) disable iff (rst)
    lowpwr_req |=> (sw_act == 2'd0) && (sw_req == 2'd0) && hsi_on && !hse_on
                   && (pll_on == '0));

endmodule

bind sysclk_src_ctrl sysclk_src_ctrl_chk #(
  .NUM_PLL (NUM_PLL),
  .DIV_W   (DIV_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lowpwr_req (lowpwr_req),
  .hsi_rdy    (hsi_rdy),
  .csi_rdy    (csi_rdy),
  .hse_rdy    (hse_rdy),
  .pll1_rdy   (pll_rdy[0]),
  .hsi_on     (hsi_on),
  .csi_on     (csi_on),
  .hse_on     (hse_on),
  .hse_byp    (hse_byp),
  .pll_on     (pll_on),
  .pll_ref    (pll_ref),
  .hsi_div    (hsi_div),
  .sw_req     (sw_req),
  .sw_act     (sw_act)
);

// File: tb/sysclk_src_ctrl_tb.sv
`timescale 1ns/1ps
module sysclk_src_ctrl_tb;

  localparam int NP  = 3;
  localparam int DW  = 2;
  localparam int DTW = 4;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lowpwr_req = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [DTW-1:0] wr_data = '0;
  logic hsi_rdy = 1'b1, csi_rdy = 1'b0, hse_rdy = 1'b0;
  logic [NP-1:0] pll_rdy = '0;
  logic hsi_on, csi_on, hse_on, hse_byp;
  logic [NP-1:0] pll_on;
  logic [1:0] pll_ref, sw_req, sw_act;
  logic [DW-1:0] hsi_div;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sysclk_src_ctrl #(.NUM_PLL(NP), .DIV_W(DW)) u_dut (
    .clk(clk), .rst(rst), .lowpwr_req(lowpwr_req), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .hsi_rdy(hsi_rdy), .csi_rdy(csi_rdy),
    .hse_rdy(hse_rdy), .pll_rdy(pll_rdy), .hsi_on(hsi_on), .csi_on(csi_on),
    .hse_on(hse_on), .hse_byp(hse_byp), .pll_on(pll_on), .pll_ref(pll_ref),
    .hsi_div(hsi_div), .sw_req(sw_req), .sw_act(sw_act)
  );

  // behavioural reference model
  logic [2:0] m_osc;   // bit0 hsi, bit1 csi, bit2 hse
  logic       m_byp;
  logic [NP-1:0] m_pll;
  logic [1:0] m_ref, m_req, m_act;
  logic [DW-1:0] m_div;

  function automatic bit src_ready(input logic [1:0] s);
    case (s)
      2'd0: return m_osc[0] && hsi_rdy;
      2'd1: return m_osc[1] && csi_rdy;
      2'd2: return m_osc[2] && hse_rdy;
      default: return m_pll[0] && pll_rdy[0];
    endcase
  endfunction

  function automatic bit in_use(input int o);
    if (int'(m_act) == o) return 1;
    return (m_act == 2'd3) && m_pll[0] && (int'(m_ref) == o);
  endfunction

  always @(posedge clk) begin
    logic [2:0] n_osc; logic n_byp; logic [NP-1:0] n_pll;
    logic [1:0] n_ref, n_req, n_act; logic [DW-1:0] n_div;
    n_osc = m_osc; n_byp = m_byp; n_pll = m_pll; n_ref = m_ref;
    n_req = m_req; n_act = m_act; n_div = m_div;
    if (rst) begin
      n_osc = 3'b001; n_byp = 0; n_pll = '0; n_ref = 0; n_req = 0; n_act = 0; n_div = '0;
    end else if (lowpwr_req) begin
      n_osc[0] = 1; n_osc[2] = 0; n_pll = '0; n_req = 0; n_act = 0;
    end else begin
      if (m_req != m_act && src_ready(m_req)) n_act = m_req;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            for (int o = 0; o < 3; o++)
              n_osc[o] = wr_data[o] || (m_osc[o] && in_use(o));
            if (!m_osc[2]) n_byp = wr_data[3];
          end
          2'd1: begin
            n_pll = wr_data[NP-1:0];
            if (m_pll[0] && m_act == 2'd3) n_pll[0] = 1;
          end
          2'd2: if (m_pll == '0) n_ref = wr_data[1:0];
          default: begin
            n_req = wr_data[1:0];
            if (!(m_ref == 2'd0 && m_pll != '0)) n_div = wr_data[3:2];
          end
        endcase
      end
    end
    m_osc = n_osc; m_byp = n_byp; m_pll = n_pll; m_ref = n_ref;
    m_req = n_req; m_act = n_act; m_div = n_div;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3", "sw_act", sw_act, m_act);
      chk("R4", "sw_req", sw_req, m_req);
      chk("R5", "hsi_on", hsi_on, m_osc[0]);
      chk("R5", "csi_on", csi_on, m_osc[1]);
      chk("R5", "hse_on", hse_on, m_osc[2]);
      chk("R9", "hse_byp", hse_byp, m_byp);
      chk("R6", "pll_on", pll_on, m_pll);
      chk("R8", "pll_ref", pll_ref, m_ref);
      chk("R7", "hsi_div", hsi_div, m_div);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      fails++;
      $display("FAIL R3 watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic wr(input logic [1:0] a, input logic [DTW-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    // R1 / R2 reset state and codes
    chk("R1", "reset sw_act", sw_act, 0);
    chk("R1", "reset hsi_on", hsi_on, 1);
    chk("R1", "reset pll_on", pll_on, 0);
    chk("R2", "reset pll_ref code", pll_ref, 0);

    // R4 pending request, R3 switch once ready
    wr(2'd0, 4'h3);
    wr(2'd3, 4'h1);
    idle(3);
    chk("R4", "pending req", sw_req, 1);
    chk("R4", "pending act", sw_act, 0);
    csi_rdy = 1;
    @(negedge clk);
    chk("R3", "switch to csi", sw_act, 1);

    // R5 in-use oscillator kept, unused one cleared
    wr(2'd0, 4'h0);
    chk("R5", "csi kept", csi_on, 1);
    chk("R5", "hsi cleared", hsi_on, 0);

    // R7 divider accepted with no PLL
    wr(2'd3, 4'h9);
    chk("R7", "div accepted", hsi_div, 2);

    // R8 reference write free, then frozen
    wr(2'd2, 4'h2);
    chk("R8", "ref accepted", pll_ref, 2);
    wr(2'd0, 4'h6);
    hse_rdy = 1;
    wr(2'd1, 4'h1);
    wr(2'd2, 4'h1);
    chk("R8", "ref frozen", pll_ref, 2);
    wr(2'd3, 4'hB);
    idle(2);
    chk("R4", "pll pending", sw_act, 1);
    pll_rdy[0] = 1;
    @(negedge clk);
    chk("R3", "switch to pll", sw_act, 3);

    // R5 reference kept, R6 PLL1 kept
    wr(2'd0, 4'h0);
    chk("R5", "hse ref kept", hse_on, 1);
    chk("R5", "csi cleared", csi_on, 0);
    wr(2'd1, 4'h0);
    chk("R6", "pll1 kept", pll_on, 1);
    wr(2'd1, 4'h2);
    chk("R6", "pll2 added", pll_on, 3);

    // R9 bypass ignored while HSE runs
    wr(2'd0, 4'hC);
    chk("R9", "byp frozen", hse_byp, 0);

    // R10 low-power entry with a colliding write
    @(negedge clk);
    lowpwr_req = 1; wr_en = 1; wr_addr = 2'd3; wr_data = 4'h2;
    @(negedge clk);
    lowpwr_req = 0; wr_en = 0;
    chk("R10", "lp act", sw_act, 0);
    chk("R10", "lp req", sw_req, 0);
    chk("R10", "lp hse off", hse_on, 0);
    chk("R10", "lp pll off", pll_on, 0);
    chk("R10", "lp hsi on", hsi_on, 1);

    // R9 bypass accepted while HSE off
    wr(2'd0, 4'h9);
    chk("R9", "byp set", hse_byp, 1);

    // R7 divider frozen with HSI reference and a PLL on
    wr(2'd2, 4'h0);
    wr(2'd1, 4'h2);
    wr(2'd3, 4'h4);
    chk("R7", "div frozen", hsi_div, 2);
    wr(2'd0, 4'h0);
    chk("R5", "hsi direct kept", hsi_on, 1);
    wr(2'd1, 4'h0);
    wr(2'd3, 4'h4);
    chk("R7", "div direct hsi", hsi_div, 1);

    // R3 / R2 switch to HSE code 2, then R5 keep HSE
    wr(2'd0, 4'h5);
    wr(2'd3, 4'h6);
    @(negedge clk);
    chk("R2", "hse code", sw_act, 2);
    wr(2'd0, 4'h0);
    chk("R5", "hse direct kept", hse_on, 1);
    chk("R5", "hsi released", hsi_on, 0);

    idle(3);
    finish_run();
  end

endmodule